// File: doc/BRIEF.md
# Integer ALU with Flags

A purely combinational integer arithmetic and logic unit for a 32-bit datapath. It takes two operands and a 4-bit mode code. It returns a result word and three status flags: carry-out, signed overflow and zero. One shared adder does all the arithmetic. Subtraction and both compare modes use it with the B operand inverted and a carry-in of one. The logic modes take a separate bitwise path.

The unit never traps. Signed add and subtract only report overflow on a flag, and the surrounding pipeline decides what to do with it. The two compare modes return 0 or 1 in bit 0. Mode codes that are not assigned produce an all-quiet output.

Top module: `int_alu`

## Requirements
- R1: Modes 0 (signed add) and 1 (unsigned add) return A+B modulo 2^32, and carry_o is the carry out of bit 31.
- R2: Modes 2 (signed subtract) and 3 (unsigned subtract) return A-B, computed as A + ~B + 1. carry_o is the carry out of bit 31 of that sum, which is 1 exactly when A >= B unsigned.
- R3: In modes 0 and 2, overflow_o is the carry into bit 31 XOR the carry out of bit 31. It is 1 exactly when the signed result does not fit in 32 bits.
- R4: In modes 1 and 3, overflow_o is always 0, whatever the operands.
- R5: Modes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B). carry_o and overflow_o are 0 in these modes.
- R6: Mode 10 (signed compare) returns 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise. The answer is correct even when A-B overflows. Bits 31:1 are 0, and carry_o and overflow_o are 0.
- R7: Mode 11 (unsigned compare) returns 1 in bit 0 when A < B as unsigned numbers. Bits 31:1, carry_o and overflow_o are 0.
- R8: In every defined mode, zero_o is 1 exactly when all 32 result bits are 0.
- R9: Undefined mode codes (8, 9, 12, 13, 14, 15) return a result of 0 with carry_o, overflow_o and zero_o all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| mode_i | input | 4 | Operation select code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Adder carry-out (arithmetic modes only) |
| overflow_o | output | 1 | Signed overflow (signed add/subtract only) |
| zero_o | output | 1 | Result is all zeros (defined modes only) |

## Verification
Overflow and the zero flag can both be set by the same vector. Adding 0x80000000 to itself wraps to an all-zero word, so carry, overflow and zero must all be high together. Subtracting two equal operands must raise zero with carry set and overflow clear. Signed compares whose difference overflows, for example 0x80000000 against 1, check that the less-than bit follows the true signed order rather than the raw sign of the difference. Each case is scored against an independent wide-arithmetic model, alongside random operands over all sixteen codes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd10,
    OP_SLTU = 4'd11
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_ARITH,
    K_LOGIC,
    K_LT_S,
    K_LT_U
  } alu_kind_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logic_sel_e;

  typedef struct packed {
    alu_kind_e  kind;
    logic       invert_b;
    logic       signed_ovf;
    logic_sel_e lsel;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output alu_ctrl_t         ctrl_o
);

  always_comb begin
    ctrl_o = '{kind: K_NONE, invert_b: 1'b0, signed_ovf: 1'b0, lsel: LG_AND};
    case (mode_i)
      OP_ADD:  begin ctrl_o.kind = K_ARITH; ctrl_o.signed_ovf = 1'b1; end
      OP_ADDU: ctrl_o.kind = K_ARITH;
      OP_SUB:  begin ctrl_o.kind = K_ARITH; ctrl_o.invert_b = 1'b1; ctrl_o.signed_ovf = 1'b1; end
      OP_SUBU: begin ctrl_o.kind = K_ARITH; ctrl_o.invert_b = 1'b1; end
      OP_AND:  begin ctrl_o.kind = K_LOGIC; ctrl_o.lsel = LG_AND; end
      OP_OR:   begin ctrl_o.kind = K_LOGIC; ctrl_o.lsel = LG_OR;  end
      OP_XOR:  begin ctrl_o.kind = K_LOGIC; ctrl_o.lsel = LG_XOR; end
      OP_NOR:  begin ctrl_o.kind = K_LOGIC; ctrl_o.lsel = LG_NOR; end
      OP_SLT:  begin ctrl_o.kind = K_LT_S;  ctrl_o.invert_b = 1'b1; end
      OP_SLTU: begin ctrl_o.kind = K_LT_U;  ctrl_o.invert_b = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (ctrl_o.signed_ovf) begin
      AST_SIGNED_OVF_ARITH_ONLY: assert (ctrl_o.kind == K_ARITH && !mode_i[0]); // R4
    end
  end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);

  localparam int LO_W = W - 1;

  logic [LO_W-1:0] lo_sum;
  logic            msb_sum;

  // Low slice and top bit are separate so the carry into the MSB is visible.
  assign {c_msb_o, lo_sum} = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
  assign msb_sum = a_i[W-1] ^ b_i[W-1] ^ c_msb_o;
  assign cout_o  = (a_i[W-1] & b_i[W-1]) | (c_msb_o & (a_i[W-1] ^ b_i[W-1]));
  assign sum_o   = {msb_sum, lo_sum};

  always_comb begin
    if (c_msb_o ^ cout_o) begin
      AST_OVF_SIGN_FLIP: assert (a_i[W-1] == b_i[W-1] && sum_o[W-1] != a_i[W-1]); // R3
    end
  end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [W-1:0]      result_o,
  output logic              carry_o,
  output logic              overflow_o,
  output logic              zero_o
);

  alu_ctrl_t      ctrl;
  logic [W-1:0]   b_eff;
  logic [W-1:0]   sum;
  logic [W-1:0]   lg_y;
  logic           c_msb;
  logic           c_out;
  logic           v_raw;
  logic           lt_s;
  logic           lt_u;

  int_alu_decode u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  assign b_eff = ctrl.invert_b ? ~b_i : b_i;

  int_alu_adder #(.W(W)) u_add (
    .a_i     (a_i),
    .b_i     (b_eff),
    .cin_i   (ctrl.invert_b),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .cout_o  (c_out)
  );

  int_alu_logic #(.W(W)) u_lg (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (ctrl.lsel),
    .y_o   (lg_y)
  );

  assign v_raw = c_msb ^ c_out;
  // Sign corrected by overflow keeps the signed order right on wrap.
  assign lt_s  = sum[W-1] ^ v_raw;
  assign lt_u  = ~c_out;

  always_comb begin
    case (ctrl.kind)
      K_ARITH: result_o = sum;
      K_LOGIC: result_o = lg_y;
      K_LT_S:  result_o = {{(W-1){1'b0}}, lt_s};
      K_LT_U:  result_o = {{(W-1){1'b0}}, lt_u};
      default: result_o = '0;
    endcase
  end

  assign carry_o    = (ctrl.kind == K_ARITH) & c_out;
  assign overflow_o = ctrl.signed_ovf & v_raw;
  assign zero_o     = (ctrl.kind != K_NONE) & ~|result_o;

  always_comb begin
    if (mode_i == OP_ADDU || mode_i == OP_SUBU) begin
      AST_NO_OVF_UNSIGNED: assert (!overflow_o); // R4
    end
    if (ctrl.kind == K_LOGIC) begin
      AST_LOGIC_FLAGS_QUIET: assert (!carry_o && !overflow_o); // R5
    end
    if (ctrl.kind == K_LT_S || ctrl.kind == K_LT_U) begin
      AST_CMP_UPPER_CLEAR: assert (result_o[W-1:1] == '0 && !carry_o && !overflow_o); // R6
    end
    if (mode_i == OP_SUBU && a_i == b_i) begin
      AST_SUB_EQUAL_ZERO: assert (zero_o && carry_o); // R8
    end
    if (ctrl.kind == K_NONE) begin
      AST_UNDEF_QUIET: assert (result_o == '0 && !carry_o && !overflow_o && !zero_o); // R9
    end
  end

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

  localparam int W = 32;

  typedef struct {
    logic [3:0]   mode;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         c;
    logic         v;
    logic         z;
    string        req;
  } exp_t;

  logic          clk = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [3:0]    mode_i = 4'd8;
  logic [W-1:0]  result_o;
  logic          carry_o;
  logic          overflow_o;
  logic          zero_o;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   cycles = 0;
  bit   drv_done = 1'b0;

  always #5 clk = ~clk;

  int_alu dut_i (
    .a_i        (a_i),
    .b_i        (b_i),
    .mode_i     (mode_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .overflow_o (overflow_o),
    .zero_o     (zero_o)
  );

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:             return "R1";
      4'd2, 4'd3:             return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd10:                  return "R6";
      4'd11:                  return "R7";
      default:                return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] m, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input string req);
    exp_t e;
    logic [W:0] s;
    bit ok;
    e.mode = m; e.a = a; e.b = b; e.req = req;
    e.res = '0; e.c = 1'b0; e.v = 1'b0; ok = 1'b1;
    case (m)
      4'd0, 4'd1: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[W-1:0]; e.c = s[W];
        e.v = (m == 4'd0) && (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      4'd2, 4'd3: begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        e.res = s[W-1:0]; e.c = s[W];
        e.v = (m == 4'd2) && (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      4'd4:  e.res = a & b;
      4'd5:  e.res = a | b;
      4'd6:  e.res = a ^ b;
      4'd7:  e.res = ~(a | b);
      4'd10: e.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'd11: e.res = {{(W-1){1'b0}}, (a < b)};
      default: ok = 1'b0;
    endcase
    e.z = ok && (e.res == '0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] m, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string req);
    @(posedge clk);
    #1;
    a_i = a; b_i = b; mode_i = m;
    q.push_back(model(m, a, b, req));
  endtask

  // Monitor: compare at the falling edge, well after inputs settled.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (result_o !== e.res || carry_o !== e.c || overflow_o !== e.v || zero_o !== e.z) begin
        n_bad++;
        $display("FAIL %s mode=%0d a=%h b=%h actual res=%h c=%b v=%b z=%b expected res=%h c=%b v=%b z=%b",
                 e.req, e.mode, e.a, e.b, result_o, carry_o, overflow_o, zero_o,
                 e.res, e.c, e.v, e.z);
      end
    end
  end

  initial begin
    // reset state: undefined code with zero operands, all quiet (R9)
    drive(4'd8, 32'h0, 32'h0, "R9");
    // R1 add, carry out and wrap
    drive(4'd0, 32'h0000_0005, 32'h0000_0007, "R1");
    drive(4'd1, 32'hFFFF_FFFF, 32'h0000_0001, "R1 R8");
    // R3 and R8 together: overflow, carry and zero in one vector
    drive(4'd0, 32'h8000_0000, 32'h8000_0000, "R3 R8");
    drive(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    drive(4'd2, 32'h8000_0000, 32'h0000_0001, "R3");
    drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
    // R4 unsigned never flags overflow on the same operands
    drive(4'd1, 32'h7FFF_FFFF, 32'h0000_0001, "R4");
    drive(4'd3, 32'h8000_0000, 32'h0000_0001, "R4");
    // R2 subtract, borrow and equal operands
    drive(4'd3, 32'h0000_0003, 32'h0000_0005, "R2");
    drive(4'd2, 32'h1234_5678, 32'h1234_5678, "R2 R8");
    // R5 logic modes
    drive(4'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, "R5");
    drive(4'd5, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R5");
    drive(4'd6, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R5 R8");
    drive(4'd7, 32'h0000_0000, 32'h0000_0000, "R5");
    // R6 signed compare across overflowing differences
    drive(4'd10, 32'h8000_0000, 32'h0000_0001, "R6");
    drive(4'd10, 32'h7FFF_FFFF, 32'h8000_0000, "R6");
    drive(4'd10, 32'hFFFF_FFFF, 32'h0000_0000, "R6");
    drive(4'd10, 32'h0000_0004, 32'h0000_0004, "R6 R8");
    // R7 unsigned compare
    drive(4'd11, 32'h0000_0000, 32'hFFFF_FFFF, "R7");
    drive(4'd11, 32'hFFFF_FFFF, 32'h0000_0000, "R7 R8");
    // R9 every undefined code, operands that would otherwise give nonzero
    drive(4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
    drive(4'd12, 32'h1234_5678, 32'h0000_0001, "R9");
    drive(4'd13, 32'h8000_0000, 32'h8000_0000, "R9");
    drive(4'd14, 32'h0000_0001, 32'h0000_0002, "R9");
    drive(4'd15, 32'hDEAD_BEEF, 32'h0000_0000, "R9");
    // random sweep over all codes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] m;
      logic [W-1:0] ra, rb;
      m  = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = (i % 7 == 0) ? ra : W'($urandom);
      drive(m, ra, rb, req_of(m));
    end
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (drv_done && q.size() == 0) begin
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual cycles=%0d expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule